// File: doc/BRIEF.md
# Vectored Interrupt Controller with Sense Logic

This block gathers five interrupt sources and presents a single vector number with a request line to a processor core. Two of the sources are external pins with selectable sense, one is a wired-OR low detect across an 8-bit input port, one is a timer overflow pulse and one is a comparator output whose rising edge, falling edge or toggle can raise an event. Each edge-type source latches a pending flag. Each source has its own enable, and a global enable gates the whole request.

The request and acknowledge pair behaves as a valid/ready handshake. `irq_valid_o` goes high while the global enable is set and at least one enabled source is pending. `irq_vector_o` names the winner. A transfer takes place on a clock edge where both `irq_valid_o` and `irq_ack_i` are high. The transfer clears the serviced edge flag and the global enable. The core may hold off the acknowledge as long as it wants: the vector can change while it waits, if a source with a lower number becomes pending or a level source lets go. A return strobe sets the global enable again. Software reaches the block through a write-only register port that holds the enables, the sense modes and a write-one-to-clear flag register.

Top module: `vic_sense`

## Requirements
- R1: Vector numbers are fixed: 1 is external pin 0, 2 is external pin 1, 3 is the port low detect, 4 is the timer overflow and 5 is the comparator. Vector 0 is kept for reset and is never requested. `irq_vector_o` reads 0 while `irq_valid_o` is low.
- R2: The global enable resets to 0. It is written by bit 7 at address 0, where bits 4:0 are the per-source enables, with bit i enabling vector i+1. While the global enable is clear, `irq_valid_o` stays low whatever the flags and the per-source enables hold.
- R3: A transfer (valid and acknowledge high on the same edge) clears the global enable, and `reti_i` sets it again. If a transfer and `reti_i` fall on the same edge, the global enable ends up clear.
- R4: A transfer clears the latched flag of the vector it serviced. A new event for that source on the same edge wins, and the flag stays set.
- R5: A write to address 2 clears each latched flag whose data bit is 1, with bit i for vector i+1. Flags whose data bit is 0 are left alone.
- R6: External pins pass through a two-flop synchronizer. Each pin has a 2-bit sense field at address 1, bits [1:0] for pin 0 and bits [3:2] for pin 1, coded 00 low level, 01 any change, 10 falling edge and 11 rising edge. An edge that the mode does not select is ignored. A pin change driven before a clock edge gives a request after the third edge and not after the second.
- R7: Level sources (an external pin in mode 00, and the port detect) are not latched. Their request follows the condition, and neither a transfer nor a write-one-clear removes it while the condition holds.
- R8: The port source requests while its enable is set and any bit of `port_pin_i` reads low after synchronization. No request is made once all bits are high, or when its enable is clear.
- R9: The comparator mode is bits [5:4] at address 1: 10 selects falling, 11 selects rising, and 00 or 01 selects toggle. The flag is set on the edge after the selected change of `cmp_out_i`.
- R10: When several enabled sources are pending, the lowest vector number is presented.
- R11: A flag latches while its per-source enable is clear. Setting the enable later raises the request.
- R12: A one-cycle `tmr_ovf_i` pulse latches the timer flag on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | External interrupt pins, asynchronous |
| port_pin_i | input | 8 | Port pins for the wired low detect, asynchronous |
| tmr_ovf_i | input | 1 | Timer overflow pulse, synchronous |
| cmp_out_i | input | 1 | Comparator output level, synchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enables, 1 sense modes, 2 flag clear |
| reg_wdata_i | input | 8 | Register write data |
| irq_valid_o | output | 1 | Interrupt request (valid) |
| irq_vector_o | output | 3 | Vector number of the request |
| irq_ack_i | input | 1 | Acknowledge (ready); a transfer is valid and ack on one edge |
| reti_i | input | 1 | Return strobe, sets the global enable |

## Verification
Two collisions are exercised. In the first, the timer flag is being acknowledged while a fresh overflow pulse is driven on the same edge. After the return strobe, the bench expects vector 4 again, because the new event must survive the clear. In the second, the acknowledge and the return strobe are driven together, and the bench judges that the request stays low afterwards, because the clear must win over the set. A scoreboard queue holds the vector expected at each handshake, and any unexpected or leftover handshake counts as a failure.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_EXT  = 2;
  localparam int NUM_SRC  = NUM_EXT + 3;
  localparam int VEC_W    = $clog2(NUM_SRC + 1);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int DATA_W   = 8;
  localparam int SENSE_W  = 2 * (NUM_EXT + 1);
  localparam int GIE_BIT  = DATA_W - 1;

  localparam int SRC_PORT = NUM_EXT;
  localparam int SRC_TMR  = NUM_EXT + 1;
  localparam int SRC_CMP  = NUM_EXT + 2;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_SENSE = 2'd1;
  localparam logic [1:0] ADDR_CLR   = 2'd2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= {W{RST_VAL}};
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vic_edge_src.sv
module vic_edge_src #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic want_rise_i,
  input  logic want_fall_i,
  input  logic lvl_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic flag_q;
  logic evt;

  assign evt = (want_rise_i & lvl_i & ~prev_q) | (want_fall_i & ~lvl_i & prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= evt | (flag_q & ~clr_i);
    end
  end

  assign pend_o = flag_q | (lvl_mode_i & ~lvl_i);

  // R4: a clear with no competing event leaves the flag low
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt) |=> !flag_q);
  // R4: a selected edge always latches, clear or not
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vic_sense.sv
module vic_sense
  import vic_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [PORT_W-1:0] port_pin_i,
  input  logic              tmr_ovf_i,
  input  logic              cmp_out_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              irq_valid_o,
  output logic [VEC_W-1:0]  irq_vector_o,
  input  logic              irq_ack_i,
  input  logic              reti_i
);
  logic               gie_q;
  logic [NUM_SRC-1:0] en_q;
  logic [SENSE_W-1:0] sense_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] masked;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] w1c_clr;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic               take;
  logic               wr_ctrl;
  logic               wr_sense;
  logic               wr_clr;
  logic [NUM_EXT-1:0] ext_s;
  logic [PORT_W-1:0]  port_s;
  logic               tmr_flag_q;
  logic               unused_wdata;

  assign unused_wdata = reg_wdata_i[GIE_BIT-1];

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_sense = reg_wr_i && (reg_addr_i == ADDR_SENSE);
  assign wr_clr   = reg_wr_i && (reg_addr_i == ADDR_CLR);
  assign take     = irq_valid_o && irq_ack_i;

  // register file and global enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      if (wr_ctrl)  en_q    <= reg_wdata_i[NUM_SRC-1:0];
      if (wr_sense) sense_q <= reg_wdata_i[SENSE_W-1:0];
      if (take)         gie_q <= 1'b0;
      else if (wr_ctrl) gie_q <= reg_wdata_i[GIE_BIT];
      else if (reti_i)  gie_q <= 1'b1;
    end
  end

  // flag clearing from handshake and from software
  always_comb begin
    ack_clr = '0;
    if (take) ack_clr[pick_idx] = 1'b1;
  end
  assign w1c_clr = wr_clr ? reg_wdata_i[NUM_SRC-1:0] : '0;
  assign clr_vec = ack_clr | w1c_clr;

  // external pins
  vic_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_pin_i), .q_o(ext_s));

  genvar e;
  generate
    for (e = 0; e < NUM_EXT; e++) begin : g_ext
      sense_e mode;
      assign mode = sense_e'(sense_q[2*e +: 2]);
      vic_edge_src #(.RST_VAL(1'b1)) u_src (
        .clk(clk), .rst_n(rst_n), .lvl_i(ext_s[e]),
        .want_rise_i(mode == SENSE_RISE || mode == SENSE_ANY),
        .want_fall_i(mode == SENSE_FALL || mode == SENSE_ANY),
        .lvl_mode_i(mode == SENSE_LOW),
        .clr_i(clr_vec[e]), .pend_o(pend[e]));
    end
  endgenerate

  // port-wide low detect, level sensitive
  vic_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d_i(port_pin_i), .q_o(port_s));
  assign pend[SRC_PORT] = ~&port_s;

  // timer overflow flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_flag_q <= 1'b0;
    else tmr_flag_q <= tmr_ovf_i | (tmr_flag_q & ~clr_vec[SRC_TMR]);
  end
  assign pend[SRC_TMR] = tmr_flag_q;

  // comparator event: 10 falling, 11 rising, otherwise toggle
  logic [1:0] cmp_mode;
  assign cmp_mode = sense_q[2*NUM_EXT +: 2];
  vic_edge_src #(.RST_VAL(1'b0)) u_cmp (
    .clk(clk), .rst_n(rst_n), .lvl_i(cmp_out_i),
    .want_rise_i(cmp_mode != 2'b10),
    .want_fall_i(cmp_mode != 2'b11),
    .lvl_mode_i(1'b0),
    .clr_i(clr_vec[SRC_CMP]), .pend_o(pend[SRC_CMP]));

  // arbitration
  assign masked = pend & en_q;
  vic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i(masked), .any_o(pick_any), .idx_o(pick_idx));

  assign irq_valid_o  = gie_q && pick_any;
  assign irq_vector_o = irq_valid_o ? VEC_W'(pick_idx) + VEC_W'(1) : '0;

  // R1: vector lies in 1..NUM_SRC when requesting, 0 otherwise
  assert_vec_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o ? (irq_vector_o >= VEC_W'(1) && irq_vector_o <= VEC_W'(NUM_SRC))
                : (irq_vector_o == '0));
  // R2: no request while the global enable is clear
  assert_gie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_valid_o);
  // R3: a transfer leaves no request on the next cycle
  assert_ack_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq_valid_o);
  // R3: a lone return strobe re-arms the global enable
  assert_reti_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take && !wr_ctrl) |=> gie_q);
  // R10: the presented vector names an enabled pending source
  assert_pick_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> masked[irq_vector_o - VEC_W'(1)]);
endmodule

// File: tb/vic_sense_bench.sv
module vic_sense_bench;
  import vic_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin = 2'b11;
  logic [7:0] port_pin = 8'hFF;
  logic       tmr_ovf = 1'b0;
  logic       cmp_out = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       irq_valid;
  logic [2:0] irq_vector;
  logic       irq_ack = 1'b0;
  logic       reti = 1'b0;

  int total = 0;
  int bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  vic_sense u_vic_sense (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .port_pin_i(port_pin),
    .tmr_ovf_i(tmr_ovf), .cmp_out_i(cmp_out), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .irq_valid_o(irq_valid),
    .irq_vector_o(irq_vector), .irq_ack_i(irq_ack), .reti_i(reti));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  // driver: expected vector goes to the scoreboard, then acknowledge
  task automatic service(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic req_is(input string tag, input int v);
    chk({tag, " valid"}, int'(irq_valid), (v != 0) ? 1 : 0);
    chk({tag, " vector"}, int'(irq_vector), v);
  endtask

  // monitor: compares every handshake against the scoreboard
  always @(posedge clk) begin
    if (rst_n && irq_valid && irq_ack) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected transfer actual=%0d expected=none", irq_vector);
      end else begin
        chk({tag_q.pop_front(), " handshake"}, int'(irq_vector), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    req_is("R1 reset idle", 0);

    // sense: ext0 rise, ext1 fall, cmp rise; enables without port
    wr(ADDR_SENSE, 8'h3B);
    wr(ADDR_CTRL, 8'h1B);
    pulse_tmr();
    req_is("R2 gie clear blocks", 0);
    wr(ADDR_CTRL, 8'h9B);
    req_is("R2 gie set", 4);
    service(4, "R12 timer");
    req_is("R3 ack clears gie", 0);
    do_reti();
    req_is("R4 flag cleared by ack", 0);

    // R6 ext0 rising mode, falling ignored, three-edge latency
    ext_pin[0] = 1'b0;
    cyc(4);
    req_is("R6 fall ignored in rise mode", 0);
    ext_pin[0] = 1'b1;
    cyc(2);
    req_is("R6 not yet after two edges", 0);
    cyc(1);
    req_is("R6 after three edges", 1);
    service(1, "R6 ext0");
    do_reti();

    ext_pin[1] = 1'b0;
    cyc(3);
    req_is("R6 ext1 falling", 2);
    service(2, "R1 ext1");
    do_reti();
    ext_pin[1] = 1'b1;
    cyc(4);
    req_is("R6 rise ignored in fall mode", 0);

    // R10 simultaneous timer and comparator
    tmr_ovf = 1'b1; cmp_out = 1'b1;
    cyc(1);
    tmr_ovf = 1'b0;
    req_is("R10 lowest wins", 4);
    service(4, "R10 first");
    do_reti();
    req_is("R10 next pending", 5);
    service(5, "R10 second");
    do_reti();
    req_is("R10 drained", 0);

    // R9 comparator toggle then falling
    wr(ADDR_SENSE, 8'h0B);
    cmp_out = 1'b0;
    cyc(1);
    req_is("R9 toggle on fall", 5);
    service(5, "R9 toggle");
    do_reti();
    wr(ADDR_SENSE, 8'h2B);
    cmp_out = 1'b1;
    cyc(2);
    req_is("R9 rise ignored in fall mode", 0);
    cmp_out = 1'b0;
    cyc(1);
    req_is("R9 falling", 5);
    service(5, "R9 fall");
    do_reti();

    // R5 write-one clear
    wr(ADDR_CTRL, 8'h1B);
    pulse_tmr();
    wr(ADDR_CLR, 8'h17);
    wr(ADDR_CTRL, 8'h9B);
    req_is("R5 zero bit keeps flag", 4);
    wr(ADDR_CTRL, 8'h1B);
    wr(ADDR_CLR, 8'h08);
    wr(ADDR_CTRL, 8'h9B);
    req_is("R5 one bit clears flag", 0);

    // R11 flag latches while disabled
    wr(ADDR_CTRL, 8'h93);
    pulse_tmr();
    req_is("R11 masked", 0);
    wr(ADDR_CTRL, 8'h9B);
    req_is("R11 enable raises", 4);
    service(4, "R11 timer");
    do_reti();

    // R4 acknowledge and new event on one edge
    pulse_tmr();
    exp_q.push_back(4); tag_q.push_back("R4 collide");
    irq_ack = 1'b1; tmr_ovf = 1'b1;
    cyc(1);
    irq_ack = 1'b0; tmr_ovf = 1'b0;
    req_is("R4 gie off after collide", 0);
    do_reti();
    req_is("R4 new event survives", 4);
    service(4, "R4 second");
    do_reti();

    // R3 acknowledge and return on one edge
    pulse_tmr();
    exp_q.push_back(4); tag_q.push_back("R3 collide");
    irq_ack = 1'b1; reti = 1'b1;
    cyc(1);
    irq_ack = 1'b0; reti = 1'b0;
    req_is("R3 ack beats reti", 0);
    do_reti();
    req_is("R3 flag gone", 0);

    // R8 and R7 port low detect
    wr(ADDR_CTRL, 8'h9F);
    port_pin[5] = 1'b0;
    cyc(2);
    req_is("R8 port low", 3);
    service(3, "R8 port");
    wr(ADDR_CLR, 8'h04);
    do_reti();
    req_is("R7 level survives ack and clear", 3);
    port_pin = 8'hFF;
    cyc(2);
    req_is("R8 port released", 0);
    wr(ADDR_CTRL, 8'h9B);
    port_pin[0] = 1'b0;
    cyc(3);
    req_is("R8 port disabled", 0);
    port_pin = 8'hFF;
    cyc(3);

    // R7 ext0 low-level mode
    wr(ADDR_SENSE, 8'h38);
    ext_pin[0] = 1'b0;
    cyc(2);
    req_is("R7 ext0 low", 1);
    ext_pin[0] = 1'b1;
    cyc(2);
    req_is("R7 level not latched", 0);

    // R6 any-change mode on ext1
    wr(ADDR_SENSE, 8'h34);
    ext_pin[1] = 1'b0;
    cyc(3);
    req_is("R6 any change fall", 2);
    service(2, "R6 any fall");
    do_reti();
    ext_pin[1] = 1'b1;
    cyc(3);
    req_is("R6 any change rise", 2);
    service(2, "R6 any rise");
    do_reti();
    req_is("R6 any drained", 0);

    chk("R1 scoreboard empty", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule